// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets logic running on a synchronous clock read and write an external asynchronous static RAM of 4096 four-bit words. The RAM shares one four-bit bus between its inputs and outputs. The host places a one-cycle request in which it gives the direction, a 12-bit word address and, for a write, the data to store. The controller then drives the RAM's three active-low strobes through phases that are counted in host clock cycles. It finishes each access with a one-cycle done pulse. For a read, the fetched word appears on the read-data output in the same cycle as that pulse.

Three parameters give the phase lengths in clock cycles: the read access time, the write strobe width and the read-to-next-access turnaround. Each one is a nanosecond figure divided by the clock period, rounded up and never less than one. The memory side has three data signals: a data output, a separate drive enable for it, and a data input. Logic at the chip pads combines these into the shared tri-state bus. The controller never asserts its drive enable while the RAM could be driving the bus. It holds write data for one cycle after the write strobe rises. After a read it keeps every strobe high for the turnaround time before it starts the next access.

Top module: `sram_ctl`

## Requirements
- R1: In reset and in the first cycle after reset, chip enable, write enable and output enable are all high (inactive), the data drive enable is low and done is low.
- R2: While no request is being served, chip enable stays high.
- R3: The controller accepts a read request (host_we low) on a clock edge in idle. For exactly ACC_CYC = max(1, ceil(T_ACC_NS / CLK_NS)) cycles after that edge, chip enable and output enable are low and write enable is high. Done is high in the cycle that follows those cycles.
- R4: The controller captures the bus value on the clock edge that ends the last read access cycle, while output enable is still low. That value sits on host_rdata while done is high and stays there until the next read.
- R5: The controller accepts a write request (host_we high) on a clock edge in idle. For exactly WP_CYC = max(1, ceil(T_WP_NS / CLK_NS)) cycles after that edge, chip enable and write enable are low, output enable is high and the latched write data is driven. The RAM stores that word at the requested address.
- R6: Write enable and chip enable rise together. The write data stays driven for one more cycle, and the drive enable is low in the cycle after that.
- R7: The data drive enable is never high while output enable is low.
- R8: The address stays unchanged for the whole time chip enable is low.
- R9: Done lasts exactly one cycle. It rises WP_CYC+1 cycles after a write is accepted and ACC_CYC+1 cycles after a read is accepted.
- R10: A request made while an access or turnaround is in progress is ignored: it does not pull chip enable low, does not produce done and does not change memory.
- R11: After a read, all strobes stay high for TURN_CYC = max(1, ceil(T_TURN_NS / CLK_NS)) cycles, counting the done cycle, before the controller can accept a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Request, sampled only in idle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 12 | Word address |
| host_wdata | input | 4 | Write data |
| host_rdata | output | 4 | Last word read |
| host_done | output | 1 | One-cycle completion pulse |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_addr | output | 12 | RAM address |
| mem_dq_o | output | 4 | Data toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 4 | Data from the shared bus |

## Verification
A wrong phase count shows in the next access. If a strobe is held one cycle too long or too short, the done pulse moves by a cycle. A read that samples too early returns a corrupted word, because the bench's RAM model drives the inverted word until its access time has passed. A state that releases or asserts the drive enable at the wrong moment shows in one of three ways within the same cycle: a bus contention flag, a lost write seen on the next read-back, or a missed hold cycle. A sequencer that accepts a request outside idle shows up within a few cycles as an extra chip-enable pulse or done pulse during the turnaround.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WP,
        ST_WH,
        ST_TURN
    } sram_st_e;

    // Whole clock cycles that cover ns nanoseconds, never fewer than one.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
`timescale 1ns/1ps
module sram_ctl_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_fsm.sv
`timescale 1ns/1ps
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int AW       = 12,
    parameter int DW       = 4,
    parameter int CW       = 2,
    parameter int ACC_CYC  = 3,
    parameter int WP_CYC   = 2,
    parameter int TURN_CYC = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_req,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          host_done,
    output logic          mem_ce_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_i,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    input  logic          tmr_zero
);
    localparam logic [CW-1:0] ACC_LD  = CW'(ACC_CYC - 1);
    localparam logic [CW-1:0] WP_LD   = CW'(WP_CYC - 1);
    localparam logic [CW-1:0] TURN_LD = CW'(TURN_CYC - 1);

    typedef struct packed {
        sram_st_e      st;
        logic          ce_n;
        logic          we_n;
        logic          oe_n;
        logic          dq_oe;
        logic          done;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
    } regs_t;

    localparam regs_t RST_V = '{
        st:    ST_IDLE,
        ce_n:  1'b1,
        we_n:  1'b1,
        oe_n:  1'b1,
        dq_oe: 1'b0,
        done:  1'b0,
        addr:  '0,
        wdata: '0,
        rdata: '0
    };

    regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (r_q.st)
            ST_IDLE: begin
                if (host_req) begin
                    r_d.addr = host_addr;
                    r_d.ce_n = 1'b0;
                    tmr_load = 1'b1;
                    if (host_we) begin
                        r_d.st    = ST_WP;
                        r_d.we_n  = 1'b0;
                        r_d.dq_oe = 1'b1;
                        r_d.wdata = host_wdata;
                        tmr_val   = WP_LD;
                    end else begin
                        r_d.st   = ST_RD;
                        r_d.oe_n = 1'b0;
                        tmr_val  = ACC_LD;
                    end
                end
            end
            ST_RD: begin
                if (tmr_zero) begin
                    r_d.rdata = mem_dq_i;
                    r_d.ce_n  = 1'b1;
                    r_d.oe_n  = 1'b1;
                    r_d.done  = 1'b1;
                    r_d.st    = ST_TURN;
                    tmr_load  = 1'b1;
                    tmr_val   = TURN_LD;
                end
            end
            ST_WP: begin
                if (tmr_zero) begin
                    r_d.we_n = 1'b1;
                    r_d.ce_n = 1'b1;
                    r_d.done = 1'b1;
                    r_d.st   = ST_WH;
                end
            end
            ST_WH: begin
                r_d.dq_oe = 1'b0;
                r_d.st    = ST_IDLE;
            end
            ST_TURN: begin
                if (tmr_zero) r_d.st = ST_IDLE;
            end
            default: r_d = RST_V;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= RST_V;
        else     r_q <= r_d;
    end

    assign host_rdata = r_q.rdata;
    assign host_done  = r_q.done;
    assign mem_ce_n   = r_q.ce_n;
    assign mem_we_n   = r_q.we_n;
    assign mem_oe_n   = r_q.oe_n;
    assign mem_addr   = r_q.addr;
    assign mem_dq_o   = r_q.wdata;
    assign mem_dq_oe  = r_q.dq_oe;
endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int AW        = 12,
    parameter int DW        = 4,
    parameter int CLK_NS    = 10,
    parameter int T_ACC_NS  = 25,
    parameter int T_WP_NS   = 20,
    parameter int T_TURN_NS = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_req,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          host_done,
    output logic          mem_ce_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_i
);
    localparam int ACC_CYC  = ns_to_cyc(T_ACC_NS, CLK_NS);
    localparam int WP_CYC   = ns_to_cyc(T_WP_NS, CLK_NS);
    localparam int TURN_CYC = ns_to_cyc(T_TURN_NS, CLK_NS);
    localparam int MAX_CYC  = max3(ACC_CYC, WP_CYC, TURN_CYC);
    localparam int CW       = $clog2(MAX_CYC + 1);

    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_zero;

    sram_ctl_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    sram_ctl_fsm #(
        .AW       (AW),
        .DW       (DW),
        .CW       (CW),
        .ACC_CYC  (ACC_CYC),
        .WP_CYC   (WP_CYC),
        .TURN_CYC (TURN_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .host_done  (host_done),
        .mem_ce_n   (mem_ce_n),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_addr   (mem_addr),
        .mem_dq_o   (mem_dq_o),
        .mem_dq_oe  (mem_dq_oe),
        .mem_dq_i   (mem_dq_i),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .tmr_zero   (tmr_zero)
    );
endmodule

// File: rtl/sram_ctl_chk.sv
`timescale 1ns/1ps
module sram_ctl_chk #(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic          mem_ce_n,
    input logic          mem_we_n,
    input logic          mem_oe_n,
    input logic [AW-1:0] mem_addr,
    input logic          mem_dq_oe,
    input logic          host_done
);
    assert_drive_safe_R7: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);

    assert_write_strobes_R5: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_ce_n && mem_dq_oe && mem_oe_n));

    assert_read_strobes_R3: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n));

    assert_data_hold_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (mem_dq_oe && mem_ce_n));

    assert_data_release_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |=> !mem_dq_oe);

    assert_addr_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        host_done |=> !host_done);

    assert_turnaround_R11: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_ce_n) && $past(!mem_oe_n)) |=> mem_ce_n);
endmodule

bind sram_ctl sram_ctl_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_addr  (mem_addr),
    .mem_dq_oe (mem_dq_oe),
    .host_done (host_done)
);

// File: tb/sim_sram_ctl.sv
`timescale 1ns/1ps
module sim_sram_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int T_ACC      = 25;
    localparam int ACC_CYC    = (25 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int WP_CYC     = (20 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int TURN_CYC   = (15 + CLK_PERIOD - 1) / CLK_PERIOD;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [11:0] host_addr = '0;
    logic [3:0]  host_wdata = '0;
    logic [3:0]  host_rdata;
    logic        host_done;
    logic        mem_ce_n, mem_we_n, mem_oe_n;
    logic [11:0] mem_addr;
    logic [3:0]  mem_dq_o;
    logic        mem_dq_oe;
    logic [3:0]  dq_bus;

    int vectors = 0;
    int fails   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_ctl u0 (
        .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_done(host_done), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(dq_bus)
    );

    // RAM model: sparse storage, drives inverted data until access time elapses.
    logic [3:0] mem [int];
    logic       acc_ok = 1'b0;
    logic       mem_drive;
    logic [3:0] mem_val;

    function automatic logic [3:0] peek(input logic [11:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return 4'h0;
    endfunction

    always @(negedge mem_ce_n) begin
        acc_ok = 1'b0;
        #(T_ACC);
        acc_ok = !mem_ce_n;
    end
    always @(posedge mem_ce_n) acc_ok = 1'b0;

    assign mem_drive = !mem_ce_n && mem_we_n && !mem_oe_n;
    always @(*) mem_val = acc_ok ? peek(mem_addr) : ~peek(mem_addr);
    assign dq_bus = mem_dq_oe ? mem_dq_o : (mem_drive ? mem_val : 4'h0);

    always @(mem_ce_n or mem_we_n or mem_addr or dq_bus) begin
        if (!mem_ce_n && !mem_we_n) mem[int'(mem_addr)] = dq_bus;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bus monitor: contention and read turnaround gap.
    int  gap = 100;
    bit  last_read = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_dq_oe && mem_drive) chk(1'b0, "R7 contention", 1, 0);
            if (!mem_ce_n) begin
                if (gap != 0 && last_read)
                    chk(gap >= TURN_CYC, "R11 gap after read", gap, TURN_CYC);
                gap = 0;
                last_read = !mem_oe_n || last_read && 1'b0;
                if (!mem_oe_n) last_read = 1'b1;
            end else begin
                gap++;
            end
        end
    end

    task automatic t_reset;
        chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes", {mem_ce_n, mem_we_n, mem_oe_n}, 7);
        chk(!mem_dq_oe && !host_done, "R1 drive/done", {mem_dq_oe, host_done}, 0);
    endtask

    task automatic t_idle;
        bit ok = 1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (!mem_ce_n || host_done) ok = 0;
        end
        chk(ok, "R2 idle chip enable", ok, 1);
    endtask

    task automatic do_write(input logic [11:0] a, input logic [3:0] d);
        int lat = 0, we_low = 0;
        bit addr_ok = 1;
        host_req = 1; host_we = 1; host_addr = a; host_wdata = d;
        while (lat < 40) begin
            @(negedge clk);
            lat++;
            host_req = 0;
            host_wdata = ~d;
            if (!mem_we_n) we_low++;
            if (!mem_ce_n && mem_addr != a) addr_ok = 0;
            if (host_done) break;
        end
        chk(lat == WP_CYC + 1, "R9 write done latency", lat, WP_CYC + 1);
        chk(we_low == WP_CYC, "R5 write pulse width", we_low, WP_CYC);
        chk(peek(a) == d, "R5 stored word", peek(a), d);
        chk(addr_ok, "R8 write address", addr_ok, 1);
        chk(mem_we_n && mem_dq_oe && mem_dq_o == d, "R6 data hold",
            {mem_we_n, mem_dq_oe, mem_dq_o}, {2'b11, d});
        @(negedge clk);
        chk(!mem_dq_oe, "R6 drive released", mem_dq_oe, 0);
        chk(!host_done, "R9 write done width", host_done, 0);
    endtask

    task automatic do_read(input logic [11:0] a, input logic [3:0] exp, input bit poke);
        int lat = 0, oe_low = 0;
        bit addr_ok = 1;
        host_req = 1; host_we = 0; host_addr = a;
        while (lat < 40) begin
            @(negedge clk);
            lat++;
            host_req = 0;
            if (!mem_oe_n) oe_low++;
            if (!mem_ce_n && mem_addr != a) addr_ok = 0;
            if (host_done) break;
        end
        chk(lat == ACC_CYC + 1, "R9 read done latency", lat, ACC_CYC + 1);
        chk(oe_low == ACC_CYC, "R3 read access cycles", oe_low, ACC_CYC);
        chk(host_rdata == exp, "R4 read data", host_rdata, exp);
        chk(addr_ok, "R8 read address", addr_ok, 1);
        if (poke) begin
            bit quiet = 1;
            host_req = 1; host_we = 1; host_addr = a; host_wdata = ~exp;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                host_req = 0;
                if (!mem_ce_n || host_done) quiet = 0;
            end
            chk(quiet, "R10 request during turnaround", quiet, 1);
            chk(peek(a) == exp, "R10 memory untouched", peek(a), exp);
        end else begin
            @(negedge clk);
            chk(!host_done, "R9 read done width", host_done, 0);
            chk(host_rdata == exp, "R4 read data held", host_rdata, exp);
            repeat (TURN_CYC - 1) @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            fails++;
            vectors++;
            $display("FAIL R9 watchdog actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 0;
        @(negedge clk);
        t_reset();
        t_idle();
        do_write(12'h000, 4'h3);
        do_write(12'hFFF, 4'hC);
        do_write(12'h5A5, 4'h9);
        do_write(12'hA5A, 4'h6);
        do_read(12'h000, 4'h3, 0);
        do_read(12'hFFF, 4'hC, 0);
        do_read(12'h5A5, 4'h9, 1);
        do_read(12'h5A5, 4'h9, 0);
        do_read(12'hA5A, 4'h6, 0);
        do_write(12'hA5A, 4'h1);
        do_read(12'hA5A, 4'h1, 0);
        do_write(12'h001, 4'hF);
        do_read(12'h000, 4'h3, 0);
        do_read(12'h001, 4'hF, 0);
        t_idle();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule